// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block sits between a 16-bit microprocessor bus and up to four banks of DRAM with multiplexed row and column addresses. The processor bus uses an asynchronous handshake. When the address strobe and the chip select are both asserted, the sequencer raises the row strobe of the bank chosen by two bank-select bits. It holds the multiplexer on the row address for a programmed number of cycles, then switches it to the column address and raises the column strobe. A data acknowledge goes back to the processor after a programmable delay. On a write, the column strobe moves one cycle later.

A free-running timer raises refresh requests. A refresh is granted only when no processor access is active. It drives all bank row strobes together, or staggers them one cycle apart. A processor access that arrives while a refresh is running waits until the refresh ends and the precharge time has passed. The processor sees this wait only as a later acknowledge. All strobes on the block's pins are active high.

Timing fields come from a configuration word. The word is taken on a load pulse while the sequencer is idle.

Top module: `dram_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, ras_o, cas_o, col_sel_o and ack_o are all low. The configuration resets to ras_low=1, pre=1, ack_mode=1, wait_en=0, stagger=0, row_hold=0 and ref_int=255.
- R2: An access starts when as_i and cs_i are high at a rising edge while the sequencer is idle, the precharge has elapsed and cfg_load_i is low. After that edge only ras_o[k] is high, where k is the binary value of bank_i.
- R3: col_sel_o rises row_hold+1 cycles after the row strobe. On a read, cas_o rises one cycle after col_sel_o.
- R4: On a write (wr_i high at the start edge), cas_o rises two cycles after col_sel_o.
- R5: ack_o rises ack_mode cycles after the row strobe, where 0 means the same cycle. It rises one cycle later still when wait_en is set and wait_req_i is high at the start edge.
- R6: A rising edge that samples as_i low during an access ends it. After that edge the row strobe, cas_o, col_sel_o and ack_o are all low.
- R7: After the row strobes fall, no row strobe rises for pre+1 cycles. An access that is already waiting starts exactly pre+1 cycles after the fall.
- R8: The timer requests a refresh every ref_int+1 cycles. With stagger=0, a refresh drives all four row strobes high for ras_low+1 cycles.
- R9: With stagger=1, bank k's row strobe rises k cycles after bank 0's, and each stays high for ras_low+1 cycles.
- R10: An access requested while a refresh is running raises its row strobe exactly pre+1 cycles after the refresh strobes fall.
- R11: cfg_i is taken on cfg_load_i only while no access or refresh is running, and is ignored otherwise. The fields are [1:0] ras_low, [3:2] pre, [5:4] ack_mode, [6] wait_en, [7] stagger, [9:8] row_hold and [17:10] ref_int.
- R12: No refresh is granted while an access holds as_i high, and the accessed bank's strobe stays the only one high. A refresh that became pending in the meantime starts pre+1 cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Processor address strobe, high = asserted |
| cs_i | input | 1 | Chip select from the address decoder |
| wr_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | 2 | Bank select |
| wait_req_i | input | 1 | Request for one extra acknowledge wait state |
| cfg_load_i | input | 1 | Load pulse for the configuration word |
| cfg_i | input | 18 | Configuration word |
| ras_o | output | 4 | Row strobe per bank |
| cas_o | output | 1 | Column strobe |
| col_sel_o | output | 1 | Address multiplexer select, 1 = column |
| ack_o | output | 1 | Data acknowledge to the processor |

## Verification
The assertions check four rules on every cycle:
- No row strobe rises before the precharge loaded at the last release has elapsed.
- The column strobe never rises unless the multiplexer already selected the column on the cycle before.
- A low address strobe clears the column strobe, the multiplexer select and the acknowledge.
- A refresh is granted only from a pending request and never cuts into a held access.

Only the bench scenarios can show the exact spacing of column select, column strobe and acknowledge for each mode and direction. The same holds for the refresh width, period and stagger offsets, the stall of an access behind a refresh, and a configuration load being ignored mid-access.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_REF
  } seq_state_e;

  // packed MSB first: bit layout row_hold[9:8] stagger[7] wait_en[6] ack_mode[5:4] pre[3:2] ras_low[1:0]
  typedef struct packed {
    logic [1:0] row_hold;
    logic       stagger;
    logic       wait_en;
    logic [1:0] ack_mode;
    logic [1:0] pre;
    logic [1:0] ras_low;
  } tim_cfg_t;

  localparam int unsigned TIM_W = $bits(tim_cfg_t);

  localparam tim_cfg_t TIM_RST = '{row_hold: 2'd0, stagger: 1'b0, wait_en: 1'b0,
                                   ack_mode: 2'd1, pre: 2'd1, ras_low: 2'd1};

endpackage

// File: rtl/dram_seq_cfg.sv
module dram_seq_cfg
  import dram_seq_pkg::*;
#(
  parameter int unsigned REF_W   = 8,
  parameter int unsigned REF_RST = 255
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   ok_i,
  input  logic [TIM_W+REF_W-1:0] cfg_i,
  output tim_cfg_t               tim_o,
  output logic [REF_W-1:0]       ref_int_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_o     <= TIM_RST;
      ref_int_o <= REF_W'(REF_RST);
    end else if (load_i && ok_i) begin
      tim_o     <= tim_cfg_t'(cfg_i[TIM_W-1:0]);
      ref_int_o <= cfg_i[TIM_W+REF_W-1:TIM_W];
    end
  end

endmodule

// File: rtl/dram_seq_ref_tmr.sv
module dram_seq_ref_tmr #(
  parameter int unsigned REF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] ref_int_i,
  input  logic             grant_i,
  output logic             pend_o
);

  logic [REF_W-1:0] tmr_q;
  logic             tick;

  // >= so that a shorter interval loaded mid-count fires at once instead of wrapping
  assign tick = (tmr_q >= ref_int_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      tmr_q  <= tick ? '0 : tmr_q + REF_W'(1);
      pend_o <= tick | (pend_o & ~grant_i);
    end
  end

  assert_grant_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> pend_o);

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     as_i,
  input  logic                     cs_i,
  input  logic                     wr_i,
  input  logic [BANK_W-1:0]        bank_i,
  input  logic                     wait_req_i,
  input  logic                     load_i,
  input  tim_cfg_t                 tim_i,
  input  logic                     ref_pend_i,
  output logic [(1<<BANK_W)-1:0]   ras_o,
  output logic                     cas_o,
  output logic                     col_sel_o,
  output logic                     ack_o,
  output logic                     ref_grant_o,
  output logic                     idle_o
);

  localparam int unsigned NB = 1 << BANK_W;
  localparam int unsigned CW = $clog2(NB + 8);

  seq_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [1:0]        pre_q;
  logic [BANK_W-1:0] bank_q;
  logic              wr_q;
  logic              extra_q;

  logic          req, start_acc, start_ref, release_now;
  logic [CW-1:0] hold_c, cas_c, ack_c, ref_last;

  assign req       = as_i && cs_i;
  assign idle_o    = (state_q == ST_IDLE);
  assign start_acc = idle_o && (pre_q == '0) && req && !load_i;
  assign start_ref = idle_o && (pre_q == '0) && !req && ref_pend_i && !load_i;
  assign ref_grant_o = start_ref;

  assign hold_c   = CW'(tim_i.row_hold) + CW'(1);
  assign cas_c    = hold_c + CW'(1) + CW'(wr_q);
  assign ack_c    = CW'(tim_i.ack_mode) + CW'(extra_q);
  assign ref_last = CW'(tim_i.ras_low) + (tim_i.stagger ? CW'(NB - 1) : CW'(0));

  assign release_now = ((state_q == ST_ACC) && !as_i) ||
                       ((state_q == ST_REF) && (cnt_q == ref_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      if (pre_q != '0) pre_q <= pre_q - 2'd1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q <= ST_ACC;
            cnt_q   <= '0;
            bank_q  <= bank_i;
            wr_q    <= wr_i;
            extra_q <= tim_i.wait_en & wait_req_i;
          end else if (start_ref) begin
            state_q <= ST_REF;
            cnt_q   <= '0;
          end
        end
        ST_ACC: begin
          if (!as_i) begin
            state_q <= ST_IDLE;
            pre_q   <= tim_i.pre;
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_REF: begin
          if (cnt_q == ref_last) begin
            state_q <= ST_IDLE;
            pre_q   <= tim_i.pre;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign col_sel_o = (state_q == ST_ACC) && (cnt_q >= hold_c);
  assign cas_o     = (state_q == ST_ACC) && (cnt_q >= cas_c);
  assign ack_o     = (state_q == ST_ACC) && (cnt_q >= ack_c);

  for (genvar k = 0; k < NB; k++) begin : g_ras
    logic [CW-1:0] lo, hi;
    assign lo = tim_i.stagger ? CW'(k) : CW'(0);
    assign hi = lo + CW'(tim_i.ras_low);
    assign ras_o[k] = ((state_q == ST_ACC) && (bank_q == BANK_W'(k))) ||
                      ((state_q == ST_REF) && (cnt_q >= lo) && (cnt_q <= hi));
  end

  // checker: cycles with every row strobe low, and the precharge loaded at the last release
  logic [CW-1:0] gap_q;
  logic [1:0]    pre_used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '1;
      pre_used_q <= '0;
    end else begin
      if (|ras_o)            gap_q <= '0;
      else if (gap_q != '1)  gap_q <= gap_q + CW'(1);
      if (release_now) pre_used_q <= tim_i.pre;
    end
  end

  assert_precharge_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|ras_o) |-> (gap_q >= CW'(pre_used_q) + CW'(1)));

  assert_col_before_cas_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_o) |-> $past(col_sel_o));

  assert_strobe_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !(ack_o || cas_o || col_sel_o));

  assert_no_refresh_in_access_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_o && as_i) |=> ($countones(ras_o) == 1));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned REF_W   = 8,
  parameter int unsigned REF_RST = 255
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     as_i,
  input  logic                     cs_i,
  input  logic                     wr_i,
  input  logic [BANK_W-1:0]        bank_i,
  input  logic                     wait_req_i,
  input  logic                     cfg_load_i,
  input  logic [TIM_W+REF_W-1:0]   cfg_i,
  output logic [(1<<BANK_W)-1:0]   ras_o,
  output logic                     cas_o,
  output logic                     col_sel_o,
  output logic                     ack_o
);

  tim_cfg_t         tim;
  logic [REF_W-1:0] ref_int;
  logic             ref_pend, ref_grant, idle;

  dram_seq_cfg #(.REF_W(REF_W), .REF_RST(REF_RST)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_load_i),
    .ok_i      (idle),
    .cfg_i     (cfg_i),
    .tim_o     (tim),
    .ref_int_o (ref_int)
  );

  dram_seq_ref_tmr #(.REF_W(REF_W)) i_ref_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_int_i (ref_int),
    .grant_i   (ref_grant),
    .pend_o    (ref_pend)
  );

  dram_seq_fsm #(.BANK_W(BANK_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .as_i        (as_i),
    .cs_i        (cs_i),
    .wr_i        (wr_i),
    .bank_i      (bank_i),
    .wait_req_i  (wait_req_i),
    .load_i      (cfg_load_i),
    .tim_i       (tim),
    .ref_pend_i  (ref_pend),
    .ras_o       (ras_o),
    .cas_o       (cas_o),
    .col_sel_o   (col_sel_o),
    .ack_o       (ack_o),
    .ref_grant_o (ref_grant),
    .idle_o      (idle)
  );

endmodule

// File: tb/test_dram_seq.sv
module test_dram_seq;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_i = 0, cs_i = 0, wr_i = 0, wait_req_i = 0, cfg_load_i = 0;
  logic [1:0]  bank_i = '0;
  logic [17:0] cfg_i = '0;
  logic [3:0]  ras_o;
  logic        cas_o, col_sel_o, ack_o;

  always #10 clk = ~clk;

  dram_seq i_dram_seq (
    .clk_i(clk), .rst_ni(rst_ni), .as_i(as_i), .cs_i(cs_i), .wr_i(wr_i),
    .bank_i(bank_i), .wait_req_i(wait_req_i), .cfg_load_i(cfg_load_i), .cfg_i(cfg_i),
    .ras_o(ras_o), .cas_o(cas_o), .col_sel_o(col_sel_o), .ack_o(ack_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int total = 0, bad = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model of the configuration
  int m_rl = 1, m_pre = 1, m_am = 1, m_we = 0, m_st = 0, m_rh = 0, m_ref = 255;

  typedef struct {int bank; int col; int cas; int ack; bit wr;} exp_t;
  exp_t q[$];
  exp_t e_mon;

  // monitor
  int  rise_t[NB];
  int  col_t, ack_t, cas_t, cas_bank, cas_cnt, rise_any_t, fall_t, last_ack_d;
  logic [3:0] ras_prev = '0;
  logic cas_prev = 0, col_prev = 0, ack_prev = 0;

  always @(negedge clk) if (rst_ni) begin
    for (int k = 0; k < NB; k++) if (ras_o[k] && !ras_prev[k]) rise_t[k] = cyc;
    if ((|ras_o) && !(|ras_prev)) rise_any_t = cyc;
    if (!(|ras_o) && (|ras_prev)) fall_t = cyc;
    if (col_sel_o && !col_prev) col_t = cyc;
    if (ack_o && !ack_prev) ack_t = cyc;
    if (cas_o && !cas_prev) begin
      cas_t = cyc;
      cas_cnt = $countones(ras_o);
      cas_bank = -1;
      for (int k = 0; k < NB; k++) if (ras_o[k]) cas_bank = k;
    end
    if (!cas_o && cas_prev) begin
      if (q.size() == 0) chk(0, "R2", "unexpected access", 1, 0);
      else begin
        e_mon = q.pop_front();
        chk(cas_bank == e_mon.bank && cas_cnt == 1, "R2", "selected bank", cas_bank, e_mon.bank);
        if (cas_bank >= 0) begin
          chk(col_t - rise_t[cas_bank] == e_mon.col, "R3", "col_sel delay",
              col_t - rise_t[cas_bank], e_mon.col);
          chk(cas_t - rise_t[cas_bank] == e_mon.cas, e_mon.wr ? "R4" : "R3", "cas delay",
              cas_t - rise_t[cas_bank], e_mon.cas);
          last_ack_d = ack_t - rise_t[cas_bank];
          chk(last_ack_d == e_mon.ack, "R5", "ack delay", last_ack_d, e_mon.ack);
        end
      end
    end
    ras_prev = ras_o; cas_prev = cas_o; col_prev = col_sel_o; ack_prev = ack_o;
  end

  task automatic load_cfg(int rl, int pre, int am, int we, int st, int rh, int rf);
    @(negedge clk);
    while (ras_o != 0) @(negedge clk);
    cfg_i = {rf[7:0], rh[1:0], st[0], we[0], am[1:0], pre[1:0], rl[1:0]};
    cfg_load_i = 1;
    @(negedge clk);
    cfg_load_i = 0;
    m_rl = rl; m_pre = pre; m_am = am; m_we = we; m_st = st; m_rh = rh; m_ref = rf;
  endtask

  // mode: 0 plain, 1 start during refresh (R10), 2 back-to-back gap (R7),
  //       3 long hold (R12), 4 config load attempt mid-access (R11)
  task automatic do_access(int bank, bit wr, bit wreq, int mode, int hold);
    exp_t e;
    bit ok;
    e.bank = bank; e.wr = wr;
    e.col = m_rh + 1;
    e.cas = m_rh + 2 + wr;
    e.ack = m_am + ((m_we != 0 && wreq) ? 1 : 0);
    q.push_back(e);
    if (mode == 1) begin
      do @(negedge clk); while (ras_o == 0);
    end else @(negedge clk);
    as_i = 1; cs_i = 1; wr_i = wr; bank_i = bank[1:0]; wait_req_i = wreq;
    do @(negedge clk); while (!(cas_o && ack_o));
    if (mode == 1)
      chk(rise_any_t - fall_t == m_pre + 1, "R10", "stall after refresh", rise_any_t - fall_t, m_pre + 1);
    if (mode == 2)
      chk(rise_any_t - fall_t == m_pre + 1, "R7", "precharge gap", rise_any_t - fall_t, m_pre + 1);
    if (mode == 3) begin
      ok = 1;
      repeat (hold) begin
        @(negedge clk);
        if (ras_o != (4'b1 << bank)) ok = 0;
      end
      chk(ok, "R12", "strobe held on bank", ras_o, 4'b1 << bank);
    end
    if (mode == 4) begin
      cfg_i = {8'd255, 2'd0, 1'b0, 1'b0, 2'd3, 2'd1, 2'd1};
      cfg_load_i = 1;
      @(negedge clk);
      cfg_load_i = 0;
    end
    @(negedge clk);
    as_i = 0; cs_i = 0; wait_req_i = 0;
    @(negedge clk);
    chk(ras_o == 0 && !cas_o && !ack_o && !col_sel_o, "R6", "release",
        {ras_o, cas_o, ack_o, col_sel_o}, 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int t1, t2, n;
    int r[NB], f[NB];
    bit found;
    repeat (3) @(negedge clk);
    chk(ras_o == 0 && !cas_o && !ack_o && !col_sel_o, "R1", "outputs in reset", ras_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(ras_o == 0 && !cas_o && !ack_o && !col_sel_o, "R1", "outputs after reset", ras_o, 0);

    // R1 defaults (ack_mode 1, row_hold 0) seen through a plain read
    do_access(0, 0, 0, 0, 0);

    // R2 R3 R5 reads to every bank
    load_cfg(1, 1, 1, 0, 0, 0, 255);
    for (int b = 0; b < NB; b++) do_access(b, 0, 0, 0, 0);
    // R4 writes
    do_access(1, 1, 0, 0, 0);
    do_access(3, 1, 0, 0, 0);
    // R5 R3 every acknowledge mode with varied row hold
    for (int am = 0; am < 4; am++) begin
      load_cfg(1, 1, am, 0, 0, 3 - am, 255);
      do_access(am, am[0], 0, 0, 0);
    end
    // R5 wait request
    load_cfg(1, 1, 1, 1, 0, 1, 255);
    do_access(0, 0, 1, 0, 0);
    do_access(2, 0, 0, 0, 0);
    do_access(3, 1, 1, 0, 0);
    load_cfg(1, 1, 1, 0, 0, 1, 255);
    do_access(1, 0, 1, 0, 0);
    // R7 back-to-back precharge gap
    load_cfg(1, 2, 1, 0, 0, 0, 255);
    do_access(0, 0, 0, 0, 0);
    do_access(3, 0, 0, 2, 0);
    load_cfg(1, 1, 1, 0, 0, 0, 255);
    do_access(2, 0, 0, 0, 0);
    do_access(1, 1, 0, 2, 0);
    // R11 load attempted mid-access is ignored
    load_cfg(1, 1, 1, 0, 0, 0, 255);
    do_access(1, 0, 0, 4, 0);
    do_access(2, 0, 0, 0, 0);
    @(negedge clk);
    chk(last_ack_d == 1, "R11", "ack delay after ignored load", last_ack_d, 1);

    // R8 all-bank refresh width and period
    load_cfg(2, 1, 1, 0, 0, 0, 30);
    for (int i = 0; i < 3; i++) begin
      do @(negedge clk); while (ras_o == 0);
      if (i == 1) t1 = cyc;
      if (i == 2) t2 = cyc;
      chk(ras_o == 4'hF, "R8", "all strobes in refresh", ras_o, 4'hF);
      n = 0;
      while (ras_o == 4'hF) begin n++; @(negedge clk); end
      chk(n == m_rl + 1, "R8", "refresh strobe width", n, m_rl + 1);
    end
    chk(t2 - t1 == m_ref + 1, "R8", "refresh period", t2 - t1, m_ref + 1);

    // R9 staggered refresh
    load_cfg(1, 1, 1, 0, 1, 0, 30);
    do @(negedge clk); while (ras_o == 0);
    chk(ras_o == 4'b0001, "R9", "bank 0 leads", ras_o, 1);
    t1 = cyc;
    for (int k = 0; k < NB; k++) begin r[k] = -1; f[k] = -1; end
    r[0] = 0;
    repeat (12) begin
      @(negedge clk);
      for (int k = 0; k < NB; k++) begin
        if (ras_o[k] && r[k] < 0) r[k] = cyc - t1;
        if (!ras_o[k] && r[k] >= 0 && f[k] < 0) f[k] = cyc - t1;
      end
    end
    for (int k = 0; k < NB; k++) begin
      chk(r[k] == k, "R9", "stagger offset", r[k], k);
      chk(f[k] - r[k] == m_rl + 1, "R9", "stagger width", f[k] - r[k], m_rl + 1);
    end

    // R10 access requested during a refresh
    load_cfg(2, 1, 1, 0, 0, 0, 30);
    do_access(2, 0, 0, 1, 0);
    load_cfg(1, 2, 2, 0, 0, 1, 30);
    do_access(1, 1, 0, 1, 0);

    // R12 long access outlasts the refresh interval
    load_cfg(1, 1, 1, 0, 0, 0, 30);
    do_access(1, 0, 0, 3, 80);
    found = 0;
    repeat (10) begin
      @(negedge clk);
      if (ras_o == 4'hF) found = 1;
    end
    chk(found, "R12", "deferred refresh after release", found, 1);

    load_cfg(1, 1, 1, 0, 0, 0, 255);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "all accesses completed", q.size(), 0);
    finish_run();
  end

endmodule